// File: doc/BRIEF.md
# Multi-slot serial receive framer

This block is the front end of a time-division serial audio receiver. It runs on the bit clock, so one `clk` period is one serial bit. It finds the start of each frame and cuts the serial data stream into slots. From each slot it delivers one word, MSB first, together with a one-cycle valid strobe and the slot index.

In master mode the block generates the frame sync itself on `fs_out`. In slave mode it follows a sync on `fs_in`. Two control inputs choose the shape of the sync:

- `fs_one_bit` selects a one-bit pulse or a sync as long as the data word.
- `fs_early` chooses, for a word-long sync only, whether the sync starts with the first data bit or one bit earlier.

A receiver-only soft reset clears all status and stops capture. The configuration inputs keep their values through it.

A frame is `SLOTS` slots, and each slot is `slot_len` bits long. Only the first `word_len` bits of a slot are kept. In slave mode the slot counter keeps running from one sync to the next. A sync that arrives out of place realigns the counter and raises a sticky framing error.

Top module: `rfs_rx_front`

## Requirements
- R1: With `fs_one_bit`=1, a master holds `fs_out` high for exactly one clock, on the first bit of slot 0. A slave starts a frame on the clock where `fs_in` rises. In slave mode `fs_out` stays low.
- R2: With `fs_one_bit`=0, a master holds `fs_out` high for `word_len` consecutive clocks in each frame.
- R3: With a word-long sync and `fs_early`=0, the first sync clock is the clock of bit 0 of slot 0. In slave mode the clock on which `fs_in` rises carries bit 0 of slot 0.
- R4: With a word-long sync and `fs_early`=1, the sync starts one clock before bit 0 of slot 0, on the last bit clock of the previous frame. With `fs_one_bit`=1, `fs_early` has no effect.
- R5: `sdi` is sampled on the rising edge of `clk`, MSB first. On the clock after the last bit of a word, `word_valid` is high for one cycle. `word_data` then holds the word right-justified, with zeros above `word_len`, and `word_slot` holds the slot index, which is 0 for the slot that starts at the sync.
- R6: A frame is `SLOTS` slots of `slot_len` clocks each. Bits at positions `word_len` and above within a slot are discarded.
- R7: In slave mode, while capturing, a rise of `fs_in` at any position other than the expected frame start sets `frame_err`. `frame_err` stays set until reset, and the slot counter restarts from the new sync.
- R8: While `soft_rst` is high, `word_valid`, `frame_err` and `fs_out` are low from the next clock on, and `sdi` has no effect.
- R9: After `rst` or `soft_rst` is released, no word is reported before a frame start. A slave waits for a rise of `fs_in`. A master lets the first frame after release pass without sync or capture and starts with the second frame; in early mode its first sync lead bit is the last bit of that first frame.
- R10: `rst` is synchronous and active high, and clears the receiver exactly as `soft_rst` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; data and sync are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Receiver-only reset; clears status and stops capture |
| master | input | 1 | 1: generate the sync on fs_out; 0: follow fs_in |
| fs_one_bit | input | 1 | 1: one-bit sync; 0: word-long sync |
| fs_early | input | 1 | Word-long sync starts one bit before slot 0 |
| word_len | input | $clog2(MAX_BITS+1) | Data bits kept per slot (1..slot_len) |
| slot_len | input | $clog2(MAX_BITS+1) | Bit clocks per slot (1..MAX_BITS) |
| sdi | input | 1 | Serial data in |
| fs_in | input | 1 | External frame sync (slave mode) |
| fs_out | output | 1 | Generated frame sync (master mode), registered |
| word_data | output | MAX_BITS | Received word, right-justified |
| word_valid | output | 1 | One-cycle strobe for word_data |
| word_slot | output | $clog2(SLOTS) | Slot index of the word |
| frame_err | output | 1 | Sticky slave framing error |

## Verification
Some behaviour is checked on every cycle by the assertions:

- soft reset blanking the strobe, the error flag and the generated sync;
- the error flag staying set;
- the one-bit master sync never lasting two clocks;
- a slave never driving a sync.

Other behaviour only the bench's scenarios can show. These include the sync waveform in each of the three styles after a release, and word contents and slot indices with junk bits past the word length. They also include realignment after a misplaced sync, and the absence of words before the first sync or while soft reset is held.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

  typedef enum logic [1:0] {
    SYNC_ONE_BIT      = 2'd0,
    SYNC_WORD_ALIGNED = 2'd1,
    SYNC_WORD_EARLY   = 2'd2
  } sync_style_e;

  // the early option only applies to a word-long sync
  function automatic sync_style_e style_of(input logic one_bit, input logic early);
    if (one_bit) return SYNC_ONE_BIT;
    if (early)   return SYNC_WORD_EARLY;
    return SYNC_WORD_ALIGNED;
  endfunction

endpackage

// File: rtl/rfs_sync_detect.sv
module rfs_sync_detect
  import rfs_pkg::*;
(
  input  logic        clk,
  input  logic        rx_clr,
  input  logic        fs_in,
  input  sync_style_e style,
  output logic        start
);

  logic fs_prev;
  logic rise_q;
  logic rise;

  assign rise = fs_in & ~fs_prev;

  // fs_prev tracks even in reset so a sync already high at release is no edge
  always_ff @(posedge clk) begin
    fs_prev <= fs_in;
    if (rx_clr) rise_q <= 1'b0;
    else        rise_q <= rise;
  end

  // early sync leads slot 0 by one bit: delay the edge to land on bit 0
  assign start = !rx_clr && ((style == SYNC_WORD_EARLY) ? rise_q : rise);

endmodule

// File: rtl/rfs_frame_seq.sv
module rfs_frame_seq
  import rfs_pkg::*;
#(
  parameter int SLOTS    = 4,
  parameter int MAX_BITS = 32,
  localparam int SW = $clog2(SLOTS),
  localparam int BW = $clog2(MAX_BITS),
  localparam int LW = $clog2(MAX_BITS + 1)
) (
  input  logic          clk,
  input  logic          rx_clr,
  input  logic          master,
  input  sync_style_e   style,
  input  logic [LW-1:0] word_len,
  input  logic [LW-1:0] slot_len,
  input  logic          start,
  output logic [SW-1:0] cur_slot,
  output logic [BW-1:0] cur_bit,
  output logic          cap_on,
  output logic          frame_err,
  output logic          fs_out
);

  localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

  logic [SW-1:0] pos_slot, nxt_slot, fol_slot;
  logic [BW-1:0] pos_bit, nxt_bit, fol_bit;
  logic [LW-1:0] bit_end;
  logic resync, armed, cap_q, err_q, fs_q, fs_next, frame_head, begin_ok;

  assign bit_end = slot_len - LW'(1);

  always_comb begin
    // position following the previous cycle
    if (LW'(pos_bit) >= bit_end) begin
      nxt_bit  = '0;
      nxt_slot = (pos_slot == LAST) ? '0 : pos_slot + 1'b1;
    end else begin
      nxt_bit  = pos_bit + 1'b1;
      nxt_slot = pos_slot;
    end
    resync   = start && !master;
    cur_slot = resync ? '0 : nxt_slot;
    cur_bit  = resync ? '0 : nxt_bit;
    // one position ahead, so the generated sync can be registered
    if (LW'(cur_bit) >= bit_end) begin
      fol_bit  = '0;
      fol_slot = (cur_slot == LAST) ? '0 : cur_slot + 1'b1;
    end else begin
      fol_bit  = cur_bit + 1'b1;
      fol_slot = cur_slot;
    end
    case (style)
      SYNC_ONE_BIT:    fs_next = (fol_slot == '0) && (fol_bit == '0);
      SYNC_WORD_EARLY: fs_next = ((fol_slot == '0) && (LW'(fol_bit) + LW'(1) < word_len)) ||
                                 ((fol_slot == LAST) && (LW'(fol_bit) == bit_end));
      default:         fs_next = (fol_slot == '0) && (LW'(fol_bit) < word_len);
    endcase
    frame_head = (cur_slot == '0) && (cur_bit == '0);
    begin_ok   = frame_head && (master ? armed : start);
    cap_on     = cap_q || begin_ok;
  end

  always_ff @(posedge clk) begin
    if (rx_clr) begin
      pos_slot <= LAST;
      pos_bit  <= BW'(bit_end);
      armed    <= 1'b0;
      cap_q    <= 1'b0;
      err_q    <= 1'b0;
      fs_q     <= 1'b0;
    end else begin
      pos_slot <= cur_slot;
      pos_bit  <= cur_bit;
      if (cur_slot == LAST) armed <= 1'b1;
      if (begin_ok) cap_q <= 1'b1;
      if (resync && cap_q && !((nxt_slot == '0) && (nxt_bit == '0))) err_q <= 1'b1;
      fs_q <= master && (armed || (cur_slot == LAST)) && fs_next;
    end
  end

  assign frame_err = err_q;
  assign fs_out    = fs_q;

endmodule

// File: rtl/rfs_shift_capture.sv
module rfs_shift_capture #(
  parameter int SLOTS    = 4,
  parameter int MAX_BITS = 32,
  localparam int SW = $clog2(SLOTS),
  localparam int BW = $clog2(MAX_BITS),
  localparam int LW = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rx_clr,
  input  logic                cap_on,
  input  logic [SW-1:0]       cur_slot,
  input  logic [BW-1:0]       cur_bit,
  input  logic [LW-1:0]       word_len,
  input  logic                sdi,
  output logic [MAX_BITS-1:0] word_data,
  output logic                word_valid,
  output logic [SW-1:0]       word_slot
);

  logic [MAX_BITS-1:0] sh_q, sh_next;
  logic in_word, last_bit;

  always_comb begin
    in_word  = cap_on && (LW'(cur_bit) < word_len);
    last_bit = in_word && (LW'(cur_bit) == word_len - LW'(1));
    if (cur_bit == '0) sh_next = {{(MAX_BITS-1){1'b0}}, sdi};
    else               sh_next = {sh_q[MAX_BITS-2:0], sdi};
  end

  always_ff @(posedge clk) begin
    if (rx_clr) begin
      sh_q       <= '0;
      word_data  <= '0;
      word_valid <= 1'b0;
      word_slot  <= '0;
    end else begin
      word_valid <= last_bit;
      if (in_word) sh_q <= sh_next;
      if (last_bit) begin
        word_data <= sh_next;
        word_slot <= cur_slot;
      end
    end
  end

endmodule

// File: rtl/rfs_rx_front.sv
module rfs_rx_front
  import rfs_pkg::*;
#(
  parameter int SLOTS    = 4,
  parameter int MAX_BITS = 32,
  localparam int SW = $clog2(SLOTS),
  localparam int BW = $clog2(MAX_BITS),
  localparam int LW = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                soft_rst,
  input  logic                master,
  input  logic                fs_one_bit,
  input  logic                fs_early,
  input  logic [LW-1:0]       word_len,
  input  logic [LW-1:0]       slot_len,
  input  logic                sdi,
  input  logic                fs_in,
  output logic                fs_out,
  output logic [MAX_BITS-1:0] word_data,
  output logic                word_valid,
  output logic [SW-1:0]       word_slot,
  output logic                frame_err
);

  logic          rx_clr;
  sync_style_e   style;
  logic          start;
  logic [SW-1:0] cur_slot;
  logic [BW-1:0] cur_bit;
  logic          cap_on;

  assign rx_clr = rst | soft_rst;
  assign style  = style_of(fs_one_bit, fs_early);

  rfs_sync_detect u_detect (
    .clk(clk), .rx_clr(rx_clr), .fs_in(fs_in), .style(style), .start(start)
  );

  rfs_frame_seq #(.SLOTS(SLOTS), .MAX_BITS(MAX_BITS)) u_seq (
    .clk(clk), .rx_clr(rx_clr), .master(master), .style(style),
    .word_len(word_len), .slot_len(slot_len), .start(start),
    .cur_slot(cur_slot), .cur_bit(cur_bit), .cap_on(cap_on),
    .frame_err(frame_err), .fs_out(fs_out)
  );

  rfs_shift_capture #(.SLOTS(SLOTS), .MAX_BITS(MAX_BITS)) u_cap (
    .clk(clk), .rx_clr(rx_clr), .cap_on(cap_on), .cur_slot(cur_slot),
    .cur_bit(cur_bit), .word_len(word_len), .sdi(sdi),
    .word_data(word_data), .word_valid(word_valid), .word_slot(word_slot)
  );

endmodule

// File: rtl/rfs_rx_front_chk.sv
module rfs_rx_front_chk (
  input logic clk,
  input logic rst,
  input logic soft_rst,
  input logic master,
  input logic fs_one_bit,
  input logic fs_out,
  input logic word_valid,
  input logic frame_err
);

  assert_soft_blank_valid_R8: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> !word_valid);

  assert_soft_blank_status_R8: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!frame_err && !fs_out));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (frame_err && !soft_rst) |=> frame_err);

  assert_one_bit_pulse_R1: assert property (@(posedge clk) disable iff (rst || soft_rst)
    (master && fs_one_bit && fs_out) |=> (!fs_out || !$stable(fs_one_bit)));

  assert_slave_no_drive_R1: assert property (@(posedge clk) disable iff (rst)
    (!master && !$past(master)) |-> !fs_out);

endmodule

bind rfs_rx_front rfs_rx_front_chk u_chk (
  .clk(clk), .rst(rst), .soft_rst(soft_rst), .master(master),
  .fs_one_bit(fs_one_bit), .fs_out(fs_out), .word_valid(word_valid),
  .frame_err(frame_err)
);

// File: tb/tb_rfs_rx_front.sv
module tb_rfs_rx_front;
  localparam int SLOTS    = 4;
  localparam int MAX_BITS = 32;
  localparam int SW = $clog2(SLOTS);
  localparam int LW = $clog2(MAX_BITS + 1);

  logic clk = 1'b0;
  logic rst, soft_rst, master, fs_one_bit, fs_early, sdi, fs_in;
  logic [LW-1:0] word_len, slot_len;
  logic fs_out, word_valid, frame_err;
  logic [MAX_BITS-1:0] word_data;
  logic [SW-1:0] word_slot;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int wl, sl, P;
  bit mode_one, mode_early;

  int              exp_slot[$];
  logic [31:0]     exp_data[$];
  string           exp_tag[$];

  always #5 clk = ~clk;

  rfs_rx_front #(.SLOTS(SLOTS), .MAX_BITS(MAX_BITS)) dut (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .master(master),
    .fs_one_bit(fs_one_bit), .fs_early(fs_early), .word_len(word_len),
    .slot_len(slot_len), .sdi(sdi), .fs_in(fs_in), .fs_out(fs_out),
    .word_data(word_data), .word_valid(word_valid), .word_slot(word_slot),
    .frame_err(frame_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // monitor: compare each reported word against the scoreboard
  always @(negedge clk) begin
    if (!rst && word_valid) begin
      if (exp_slot.size() == 0) begin
        check(1'b0, "R9", "unexpected word", word_data, 32'h0);
      end else begin
        int s;
        logic [31:0] d;
        string t;
        s = exp_slot.pop_front();
        d = exp_data.pop_front();
        t = exp_tag.pop_front();
        check(word_slot == SW'(s), t, "word slot", 32'(word_slot), 32'(s));
        check(word_data == d, t, "word data (R5/R6)", word_data, d);
      end
    end
  end

  function automatic bit fs_exp(input int j);
    int m;
    m = j % P;
    if (mode_one)   return (j >= P) && (m == 0);
    if (mode_early) return (j >= P - 1) && ((m < wl - 1) || (m == P - 1));
    return (j >= P) && (m < wl);
  endfunction

  task automatic set_mode(input bit m, input bit one, input bit early, input int w, input int s);
    master = m; fs_one_bit = one; fs_early = early;
    mode_one = one; mode_early = early && !one;
    wl = w; sl = s; P = SLOTS * s;
    word_len = LW'(w); slot_len = LW'(s);
  endtask

  task automatic drive_frame(input int fr, input bit push, input int stop,
                             input bit trail, input bit chk_fs, input string tag);
    logic [31:0] words[SLOTS];
    logic [31:0] mask;
    mask = (wl >= 32) ? 32'hFFFF_FFFF : ((32'h1 << wl) - 32'h1);
    for (int s = 0; s < SLOTS; s++) words[s] = $urandom & mask;
    for (int p = 0; p < stop; p++) begin
      int s;
      int b;
      s = p / sl;
      b = p % sl;
      if (mode_one)        fs_in = (p == 0);
      else if (mode_early) fs_in = (p < wl - 1) || (trail && p == P - 1);
      else                 fs_in = (p < wl);
      sdi = (b < wl) ? words[s][wl-1-b] : 1'($urandom);
      if (push && b == wl - 1) begin
        exp_slot.push_back(s);
        exp_data.push_back(words[s]);
        exp_tag.push_back(tag);
      end
      @(negedge clk);
      if (chk_fs)
        check(fs_out == fs_exp(fr * P + p + 1), tag, "fs_out", 32'(fs_out),
              32'(fs_exp(fr * P + p + 1)));
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      fs_in = 1'b0; sdi = 1'($urandom);
      @(negedge clk);
    end
  endtask

  task automatic end_scn(input string tag);
    fs_in = 1'b0; soft_rst = 1'b1;
    repeat (3) @(negedge clk);
    check(exp_slot.size() == 0, tag, "words left in scoreboard", 32'(exp_slot.size()), 32'h0);
    check(!word_valid && !fs_out && !frame_err, "R8", "status under soft reset",
          {29'h0, word_valid, fs_out, frame_err}, 32'h0);
  endtask

  initial begin
    rst = 1'b1; soft_rst = 1'b0; sdi = 1'b0; fs_in = 1'b0;
    set_mode(1'b0, 1'b0, 1'b0, 8, 12);
    repeat (3) @(negedge clk);
    check(!word_valid && !fs_out && !frame_err, "R10", "reset state",
          {29'h0, word_valid, fs_out, frame_err}, 32'h0);
    rst = 1'b0;

    // slave, word sync aligned with slot 0
    idle(20);
    for (int f = 0; f < 3; f++) drive_frame(f, 1'b1, P, 1'b0, 1'b0, "R3");
    end_scn("R3");

    // slave, word sync one bit early; junk bits past word length
    set_mode(1'b0, 1'b0, 1'b1, 5, 9);
    soft_rst = 1'b0;
    fs_in = 1'b1; sdi = 1'b0; @(negedge clk);
    for (int f = 0; f < 3; f++) drive_frame(f, 1'b1, P, f < 2, 1'b0, "R4");
    end_scn("R6");

    // slave, one-bit sync with the early control set (no effect)
    set_mode(1'b0, 1'b1, 1'b1, 7, 7);
    soft_rst = 1'b0;
    idle(4);
    for (int f = 0; f < 3; f++) drive_frame(f, 1'b1, P, 1'b0, 1'b0, "R1");
    end_scn("R4");

    // slave framing error and realignment
    set_mode(1'b0, 1'b0, 1'b0, 8, 12);
    soft_rst = 1'b0;
    drive_frame(0, 1'b1, P, 1'b0, 1'b0, "R7");
    check(frame_err == 1'b0, "R7", "no error on clean frame", 32'(frame_err), 32'h0);
    drive_frame(0, 1'b1, sl + 3, 1'b0, 1'b0, "R7");
    drive_frame(0, 1'b1, P, 1'b0, 1'b0, "R7");
    check(frame_err == 1'b1, "R7", "error after misplaced sync", 32'(frame_err), 32'h1);
    drive_frame(0, 1'b1, P, 1'b0, 1'b0, "R7");
    check(frame_err == 1'b1, "R7", "error sticky", 32'(frame_err), 32'h1);
    end_scn("R7");

    // data and sync ignored under soft reset, then wait for sync
    drive_frame(0, 1'b0, P, 1'b0, 1'b0, "R8");
    drive_frame(0, 1'b0, P, 1'b0, 1'b0, "R8");
    check(!word_valid && !frame_err, "R8", "quiet while held",
          {30'h0, word_valid, frame_err}, 32'h0);
    soft_rst = 1'b0;
    idle(30);
    drive_frame(0, 1'b1, P, 1'b0, 1'b0, "R9");
    end_scn("R9");

    // master, word sync aligned
    set_mode(1'b1, 1'b0, 1'b0, 6, 10);
    soft_rst = 1'b0;
    for (int f = 0; f < 3; f++) drive_frame(f, f > 0, P, 1'b0, 1'b1, "R2");
    end_scn("R9");

    // master, word sync early
    set_mode(1'b1, 1'b0, 1'b1, 6, 10);
    soft_rst = 1'b0;
    for (int f = 0; f < 3; f++) drive_frame(f, f > 0, P, 1'b0, 1'b1, "R4");
    end_scn("R4");

    // master, one-bit sync
    set_mode(1'b1, 1'b1, 1'b0, 6, 10);
    soft_rst = 1'b0;
    for (int f = 0; f < 3; f++) drive_frame(f, f > 0, P, 1'b0, 1'b1, "R1");
    end_scn("R1");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule